// File: doc/BRIEF.md
# Ethernet Transmit Frame Builder

This block turns one transmit request into the complete byte sequence that a serializer puts on a CSMA/CD medium. The host presents the destination address bytes and then the payload bytes on a byte-wide valid/ready stream. The block adds a fixed preamble and a start-of-frame delimiter ahead of them. It inserts the station's own source address after the destination field. It can close the frame with a 16-bit or a 32-bit check sequence, which is computed while the bytes go out.

The address field length is taken from configuration. It can be anything from zero to six bytes, and the destination and source fields always use the same length. The station address and the check-sequence mode are also configuration inputs. All three are captured when a frame starts and stay fixed until that frame ends. The output is a valid/ready byte stream with a flag on the final byte. Destination and payload bytes pass straight through, so a stalled output also stalls the input.

Top module: `eth_tx_framer`

## Requirements
- R1: While reset is held low, out_valid and in_ready are both 0.
- R2: A frame starts when in_valid is high while the block is idle. The frame opens with seven bytes of 0x55 and then one byte of 0xD5. in_ready stays low while these eight bytes are produced.
- R3: After the delimiter, the block passes exactly N input bytes through, in their input order, as the destination field. N is cfg_addr_len, and any value above 6 behaves as 6.
- R4: The source field follows the destination field. It is N bytes long, and source byte k (k = 0 first) equals cfg_station_addr[8k+7:8k].
- R5: With N = 0, both address fields are omitted, and the first payload byte directly follows 0xD5.
- R6: Payload bytes pass through unchanged and in order. The input byte that carries in_last is the final payload byte.
- R7: cfg_crc_mode 2'b10 or 2'b11 appends four bytes. To form them, a 32-bit register preset to all ones runs the reflected polynomial 0xEDB88320 over the address and payload bytes, taking each byte's bit 0 first. The result is complemented, and its lowest byte is sent first.
- R8: cfg_crc_mode 2'b01 appends two bytes. To form them, a 16-bit register preset to 0xFFFF shifts toward its MSB with polynomial 0x1021, fed with each address and payload byte bit 0 first. The block sends the bit-reversed bits [15:8] first and then the bit-reversed bits [7:0].
- R9: With cfg_crc_mode 2'b00, no check bytes follow, and out_last is raised on the final payload byte.
- R10: out_last is high on exactly one byte per frame, the final one.
- R11: While out_valid is high and out_ready is low, the output byte holds and nothing advances. The next cycle shows the same out_data with out_valid still high.
- R12: Configuration inputs are captured at frame start. Changing them mid-frame has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_station_addr | input | 48 | Station address; byte k goes out as source byte k |
| cfg_addr_len | input | 3 | Address field length in bytes (0..6, larger values act as 6) |
| cfg_crc_mode | input | 2 | 00 none, 01 16-bit, 10/11 32-bit check sequence |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Destination address bytes, then payload bytes |
| in_last | input | 1 | Marks the final payload byte |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Marks the final byte of the frame |
| out_ready | input | 1 | Downstream accepts the output byte |

## Verification
A sequencer that counts wrongly shows up right away in the byte stream. It lengthens or shortens the preamble or an address field, and the misalignment then runs through every later byte compared against the bench's frame model. A corrupt check-sequence register stays hidden until the last two or four bytes of the frame, but it always shows there, so every test frame is compared through its final byte. Configuration captured at the wrong time only shows when the inputs change mid-frame, and one scenario does exactly that.

// File: rtl/eth_tx_pkg.sv
// Shared types and check-sequence step functions for the transmit frame builder.
// Assumes bytes are serialized bit 0 first, so each step consumes data bit 0 first.
package eth_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_DST,
        ST_SRC,
        ST_PAY,
        ST_FCS
    } tx_state_t;

    localparam logic [7:0]  PRE_BYTE  = 8'h55;
    localparam logic [7:0]  SFD_BYTE  = 8'hD5;
    localparam logic [31:0] POLY32_RF = 32'hEDB88320;
    localparam logic [15:0] POLY16    = 16'h1021;

    // One byte through the reflected 32-bit check register.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ POLY32_RF;
            else             r = r >> 1;
        end
        return r;
    endfunction

    // One byte through the MSB-shifting 16-bit check register, data bit 0 first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[15] ^ d[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ POLY16;
        end
        return r;
    endfunction

    // Mirror the bit order of a byte.
    function automatic logic [7:0] bitrev8(input logic [7:0] d);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = d[7 - i];
        return r;
    endfunction

endpackage

// File: rtl/eth_tx_crc.sv
// Running check-sequence registers for both widths.
// Assumes init and upd are never high together; init wins if they are.
module eth_tx_crc
    import eth_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        upd,
    input  logic [7:0]  data,
    output logic [31:0] crc32,
    output logic [15:0] crc16
);

    // Preset at frame start, fold in each accepted covered byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc32 <= '1;
            crc16 <= '1;
        end else if (init) begin
            crc32 <= '1;
            crc16 <= '1;
        end else if (upd) begin
            crc32 <= crc32_step(crc32, data);
            crc16 <= crc16_step(crc16, data);
        end
    end

    // R7: a preset always leaves both registers at all ones.
    p_preset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (crc32 == 32'hFFFF_FFFF) && (crc16 == 16'hFFFF));

    // R11: with no update and no preset the registers hold.
    p_crc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !upd) |=> $stable(crc32) && $stable(crc16));

endmodule

// File: rtl/eth_tx_seq.sv
// Frame sequencer: walks preamble, delimiter, address fields, payload and check bytes.
// Assumes destination and payload bytes arrive on the input stream, with in_last on the
// final payload byte; in_last seen while in the destination field is ignored.
module eth_tx_seq
    import eth_tx_pkg::*;
#(
    parameter int PRE_LEN  = 7,
    parameter int MAX_ADDR = 6,
    localparam int SA_W    = 8 * MAX_ADDR,
    localparam int LEN_W   = $clog2(MAX_ADDR + 1),
    localparam int CNT_MAX = (PRE_LEN > MAX_ADDR) ? PRE_LEN : MAX_ADDR,
    localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SA_W-1:0]  cfg_station_addr,
    input  logic [LEN_W-1:0] cfg_addr_len,
    input  logic [1:0]       cfg_crc_mode,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    input  logic             out_ready,
    input  logic [31:0]      crc32,
    input  logic [15:0]      crc16,
    output logic             crc_init,
    output logic             crc_upd
);

    tx_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] alen;
    logic [1:0]       mode;
    logic [SA_W-1:0]  sa;

    logic             fire;
    logic             fcs_on;
    logic             fcs_wide;
    logic             fcs_end;
    logic             addr_end;
    logic [LEN_W-1:0] len_clamped;
    logic [31:0]      crc32_out;
    logic [SA_W-1:0]  sa_shift;

    // Clamp the requested address length to the supported maximum.
    always_comb begin
        if (int'(cfg_addr_len) > MAX_ADDR) len_clamped = LEN_W'(MAX_ADDR);
        else                               len_clamped = cfg_addr_len;
    end

    // Decode the captured mode and the end points of the counted fields.
    always_comb begin
        fcs_on    = (mode != 2'b00);
        fcs_wide  = mode[1];
        fcs_end   = (int'(cnt) == (fcs_wide ? 3 : 1));
        addr_end  = (int'(cnt) == int'(alen) - 1);
        crc32_out = ~crc32 >> (8 * int'(cnt));
        sa_shift  = sa >> (8 * int'(cnt));
    end

    // Select the output byte and the handshake for the current field.
    always_comb begin
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_last  = 1'b0;
        in_ready  = 1'b0;
        unique case (state)
            ST_PRE: begin
                out_valid = 1'b1;
                out_data  = PRE_BYTE;
            end
            ST_SFD: begin
                out_valid = 1'b1;
                out_data  = SFD_BYTE;
            end
            ST_DST: begin
                out_valid = in_valid;
                out_data  = in_data;
                in_ready  = out_ready;
            end
            ST_SRC: begin
                out_valid = 1'b1;
                out_data  = sa_shift[7:0];
            end
            ST_PAY: begin
                out_valid = in_valid;
                out_data  = in_data;
                out_last  = in_valid && in_last && !fcs_on;
                in_ready  = out_ready;
            end
            ST_FCS: begin
                out_valid = 1'b1;
                out_last  = fcs_end;
                if (fcs_wide)          out_data = crc32_out[7:0];
                else if (cnt == '0)    out_data = bitrev8(crc16[15:8]);
                else                   out_data = bitrev8(crc16[7:0]);
            end
            default: ;
        endcase
    end

    // Handshake strobes toward the check-sequence unit.
    always_comb begin
        fire     = out_valid && out_ready;
        crc_init = (state == ST_IDLE) && in_valid;
        crc_upd  = fire && ((state == ST_DST) || (state == ST_SRC) || (state == ST_PAY));
    end

    // Field sequencing and configuration capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            alen  <= '0;
            mode  <= 2'b00;
            sa    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        state <= ST_PRE;
                        cnt   <= '0;
                        alen  <= len_clamped;
                        mode  <= cfg_crc_mode;
                        sa    <= cfg_station_addr;
                    end
                end
                ST_PRE: begin
                    if (fire) begin
                        if (int'(cnt) == PRE_LEN - 1) begin
                            state <= ST_SFD;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_SFD: begin
                    if (fire) state <= (alen != '0) ? ST_DST : ST_PAY;
                end
                ST_DST: begin
                    if (fire) begin
                        if (addr_end) begin
                            state <= ST_SRC;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_SRC: begin
                    if (fire) begin
                        if (addr_end) begin
                            state <= ST_PAY;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_PAY: begin
                    if (fire && in_last) begin
                        state <= fcs_on ? ST_FCS : ST_IDLE;
                        cnt   <= '0;
                    end
                end
                ST_FCS: begin
                    if (fire) begin
                        if (fcs_end) begin
                            state <= ST_IDLE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R11: a generated byte waiting on out_ready holds steady.
    p_gen_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready &&
         (state == ST_PRE || state == ST_SFD || state == ST_SRC || state == ST_FCS))
        |=> out_valid && $stable(out_data));

    // R2: the first byte after leaving idle is a preamble byte.
    p_start_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_IDLE && state != ST_IDLE) |-> (out_valid && out_data == PRE_BYTE));

    // R2: after the delimiter goes out the next field is address or payload.
    p_sfd_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SFD && fire) |=> (state == ST_DST || state == ST_PAY));

    // R3: the captured address length never exceeds the maximum.
    p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(alen) <= MAX_ADDR);

    // R3: the field counter stays inside the destination field.
    p_dst_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DST) |-> int'(cnt) < int'(alen));

    // R10: the last flag only accompanies a valid byte.
    p_last_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R10: an accepted last byte returns the sequencer to idle.
    p_last_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last && out_ready) |=> state == ST_IDLE);

    // R12: captured configuration holds while a frame is in progress.
    p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != ST_IDLE) |-> ($stable(alen) && $stable(mode) && $stable(sa)));

endmodule

// File: rtl/eth_tx_framer.sv
// Transmit frame builder top: sequencer plus check-sequence unit.
// Assumes the downstream serializer consumes bytes through out_valid/out_ready.
module eth_tx_framer
    import eth_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [47:0] cfg_station_addr,
    input  logic [2:0]  cfg_addr_len,
    input  logic [1:0]  cfg_crc_mode,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        in_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last,
    input  logic        out_ready
);

    logic [31:0] crc32;
    logic [15:0] crc16;
    logic        crc_init;
    logic        crc_upd;

    eth_tx_seq #(
        .PRE_LEN  (7),
        .MAX_ADDR (6)
    ) i_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_station_addr (cfg_station_addr),
        .cfg_addr_len     (cfg_addr_len),
        .cfg_crc_mode     (cfg_crc_mode),
        .in_valid         (in_valid),
        .in_data          (in_data),
        .in_last          (in_last),
        .in_ready         (in_ready),
        .out_valid        (out_valid),
        .out_data         (out_data),
        .out_last         (out_last),
        .out_ready        (out_ready),
        .crc32            (crc32),
        .crc16            (crc16),
        .crc_init         (crc_init),
        .crc_upd          (crc_upd)
    );

    eth_tx_crc i_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .upd   (crc_upd),
        .data  (out_data),
        .crc32 (crc32),
        .crc16 (crc16)
    );

    // R1: nothing is offered or accepted while reset is held.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!rst_n -> (!out_valid && !in_ready)));

    // R11: input is only taken when the byte also leaves.
    p_pass_through_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> out_ready);

endmodule

// File: tb/test_eth_tx_framer.sv
// Directed bench: one task per scenario, each comparing the whole frame against a model.
module test_eth_tx_framer;

    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] STATION = 48'h6655_4433_2211;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [47:0] cfg_station_addr;
    logic [2:0]  cfg_addr_len;
    logic [1:0]  cfg_crc_mode;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        in_last;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_last;
    logic        out_ready;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    eth_tx_framer i_eth_tx_framer (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_station_addr (cfg_station_addr),
        .cfg_addr_len     (cfg_addr_len),
        .cfg_crc_mode     (cfg_crc_mode),
        .in_valid         (in_valid),
        .in_data          (in_data),
        .in_last          (in_last),
        .in_ready         (in_ready),
        .out_valid        (out_valid),
        .out_data         (out_data),
        .out_last         (out_last),
        .out_ready        (out_ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] d);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[7 - i] = d[i];
        return r;
    endfunction

    // Send one frame and compare every output byte and last flag to the model.
    task automatic run_frame(input int alen, input logic [1:0] mode, input int plen,
                             input int seed, input bit stall, input bit change,
                             input string req);
        logic [7:0]  stream [64];
        logic [7:0]  expb   [128];
        logic [7:0]  gotb   [128];
        bit          gotl   [128];
        int          nstr, nexp, ngot, idx, eff, cyc;
        logic [31:0] c32;
        logic [15:0] c16;
        bit          fb, pend, prev_hold, r2_bad, done;
        logic [7:0]  prev_data;

        eff  = (alen > 6) ? 6 : alen;
        nstr = 0;
        for (int i = 0; i < eff; i++) begin stream[nstr] = 8'hA0 + 8'(i); nstr++; end
        for (int i = 0; i < plen; i++) begin stream[nstr] = 8'((seed * 7 + i * 13) & 8'hFF); nstr++; end

        nexp = 0;
        for (int i = 0; i < 7; i++) begin expb[nexp] = 8'h55; nexp++; end
        expb[nexp] = 8'hD5; nexp++;
        for (int i = 0; i < eff; i++) begin expb[nexp] = stream[i]; nexp++; end
        for (int i = 0; i < eff; i++) begin expb[nexp] = STATION[8*i +: 8]; nexp++; end
        for (int i = eff; i < nstr; i++) begin expb[nexp] = stream[i]; nexp++; end
        c32 = 32'hFFFF_FFFF;
        c16 = 16'hFFFF;
        for (int j = 8; j < nexp; j++) begin
            for (int b = 0; b < 8; b++) begin
                fb  = c32[0] ^ expb[j][b];
                c32 = {1'b0, c32[31:1]};
                if (fb) c32 = c32 ^ 32'hEDB8_8320;
                fb  = c16[15] ^ expb[j][b];
                c16 = {c16[14:0], 1'b0};
                if (fb) c16 = c16 ^ 16'h1021;
            end
        end
        c32 = ~c32;
        if (mode[1]) begin
            for (int i = 0; i < 4; i++) begin expb[nexp] = c32[8*i +: 8]; nexp++; end
        end else if (mode == 2'b01) begin
            expb[nexp] = rev8(c16[15:8]); nexp++;
            expb[nexp] = rev8(c16[7:0]);  nexp++;
        end

        cfg_addr_len     = 3'(alen);
        cfg_crc_mode     = mode;
        cfg_station_addr = STATION;

        idx = 0; ngot = 0; pend = 0; prev_hold = 0; r2_bad = 0; done = 0; prev_data = 0;
        for (cyc = 0; cyc < 2000 && !done; cyc++) begin
            @(negedge clk);
            if (change && cyc == 12) begin
                cfg_addr_len     = 3'd1;
                cfg_crc_mode     = 2'b00;
                cfg_station_addr = 48'h0;
            end
            in_valid  = (idx < nstr) && (pend || !stall || (cyc % 4) != 2);
            in_data   = (idx < nstr) ? stream[idx] : 8'h00;
            in_last   = (idx == nstr - 1);
            out_ready = !stall || (cyc % 3) != 1;
            #1;
            if (prev_hold)
                check(out_valid && out_data == prev_data, "R11", "held byte",
                      int'(out_data), int'(prev_data));
            if (out_valid && ngot < 8 && in_ready) r2_bad = 1;
            pend      = in_valid && !in_ready;
            prev_hold = out_valid && !out_ready;
            prev_data = out_data;
            if (in_valid && in_ready) idx++;
            if (out_valid && out_ready && ngot < 128) begin
                gotb[ngot] = out_data;
                gotl[ngot] = out_last;
                ngot++;
                if (out_last) done = 1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        out_ready = 1'b1;
        cfg_station_addr = STATION;

        check(done, req, "frame completed", done, 1);
        check(!r2_bad, "R2", "in_ready low during preamble", r2_bad, 0);
        check(ngot == nexp, req, "frame length", ngot, nexp);
        for (int k = 0; k < nexp && k < ngot; k++) begin
            check(gotb[k] == expb[k], req, $sformatf("byte %0d", k), int'(gotb[k]), int'(expb[k]));
            check(gotl[k] == (k == nexp - 1), "R10", $sformatf("last flag at byte %0d", k),
                  int'(gotl[k]), int'(k == nexp - 1));
        end
    endtask

    // R1: quiet outputs while reset is held, even with input offered.
    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b1; in_data = 8'h11; in_last = 1'b0; out_ready = 1'b1;
        cfg_station_addr = STATION; cfg_addr_len = 3'd6; cfg_crc_mode = 2'b10;
        repeat (3) begin
            @(negedge clk);
            #1;
            check(!out_valid && !in_ready, "R1", "outputs during reset",
                  int'({out_valid, in_ready}), 0);
        end
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R2 R3 R4 R6 R7 R10: full address, 32-bit check.
    task automatic t_basic();
        run_frame(6, 2'b10, 10, 1, 0, 0, "R7");
    endtask

    // R8: short address with 16-bit check.
    task automatic t_crc16();
        run_frame(2, 2'b01, 5, 2, 0, 0, "R8");
    endtask

    // R9: no check bytes, last flag on final payload byte.
    task automatic t_nocrc();
        run_frame(4, 2'b00, 3, 3, 0, 0, "R9");
    endtask

    // R5: zero address length.
    task automatic t_zero_addr();
        run_frame(0, 2'b10, 6, 4, 0, 0, "R5");
    endtask

    // R3: length above six acts as six; mode 11 acts as 32-bit.
    task automatic t_clamp();
        run_frame(7, 2'b11, 4, 5, 0, 0, "R3");
    endtask

    // R11: output stalls and input gaps.
    task automatic t_stall();
        run_frame(3, 2'b01, 9, 6, 1, 0, "R11");
    endtask

    // R12: configuration changed mid-frame is ignored.
    task automatic t_cfg_change();
        run_frame(5, 2'b10, 7, 7, 0, 1, "R12");
    endtask

    // R6: single payload byte.
    task automatic t_one_byte();
        run_frame(1, 2'b10, 1, 8, 0, 0, "R6");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0; out_ready = 1'b1;
        t_reset();
        t_basic();
        t_crc16();
        t_nocrc();
        t_zero_addr();
        t_clamp();
        t_stall();
        t_cfg_change();
        t_one_byte();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule